// File: doc/BRIEF.md
# Two-level carry-select adder/subtractor

This block adds or subtracts two 32-bit two's-complement words. A single select input chooses the operation. For subtraction the block inverts every bit of the second operand and feeds a carry-in of 1 into the least significant position. Addition and subtraction therefore share one datapath.

The carry is not passed through one long chain. The word is split at bit 16. The lower half is summed with the true carry-in. The upper half is summed twice at the same time, once with an assumed carry-in of 0 and once with an assumed carry-in of 1. The real carry out of the lower half then selects one of the two upper results. Each 16-bit half repeats this split at bit 8, using 8-bit ripple adders. As a result, the longest carry path is one 8-bit ripple plus two multiplexer levels.

The result, the carry-out and a signed-overflow flag are captured in output registers on each rising clock edge. A synchronous active-high reset clears them.

Top module: `addsub_csel32`

## Requirements
- R1: With `op_sub` = 0, `sum_q` equals (`a_in` + `b_in`) mod 2^32 after the next rising edge.
- R2: With `op_sub` = 1, `sum_q` equals (`a_in` − `b_in`) mod 2^32 after the next rising edge.
- R3: In add mode, `cout_q` is the carry out of bit 31, i.e. 1 exactly when the unsigned sum exceeds 2^32 − 1.
- R4: In subtract mode, `cout_q` is 1 exactly when no borrow occurs, i.e. when `a_in` ≥ `b_in` as unsigned numbers.
- R5: In add mode, `ovf_q` is 1 exactly when both operands have equal sign bits (bit 31) and the result sign bit differs from them.
- R6: In subtract mode, `ovf_q` is 1 exactly when the operand sign bits differ and the result sign bit differs from that of `a_in`.
- R7: While `rst` is high at a rising edge, all outputs are 0 after that edge.
- R8: The outputs reflect the inputs sampled at the previous rising edge, with one cycle of latency, and a new operation can be applied every cycle.
- R9: Carries that cross the byte boundaries (bit 7 to 8, bit 23 to 24) and the half boundary (bit 15 to 16) produce the same result as a full-width addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sub | input | 1 | Operation select: 0 add, 1 subtract |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| sum_q | output | 32 | Registered result |
| cout_q | output | 1 | Registered carry out of bit 31 (no-borrow flag when subtracting) |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
The assertions compare each registered output with the operands sampled at the previous edge. They assume that `op_sub`, `a_in` and `b_in` are stable and known at every rising edge once reset is released. The bench changes the inputs only on falling edges and always drives defined values, which meets that assumption. The stimulus includes the sign-boundary words, all-ones, and carries that cross each select boundary, as well as a long pseudo-random run that alternates between the two operations from cycle to cycle.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  parameter int WORD_W = 32;
  parameter int HALF_W = WORD_W / 2;
  parameter int LEAF_W = HALF_W / 2;
endpackage

// File: rtl/csel_rca.sv
module csel_rca #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end
  assign co = c[W];
endmodule

// File: rtl/csel_block.sv
module csel_block #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int LO = W / 2;
  localparam int HI = W - LO;

  logic [LO-1:0] s_lo;
  logic          c_lo;
  logic [HI-1:0] s_hi0, s_hi1;
  logic          c_hi0, c_hi1;

  csel_rca #(.W(LO)) u_lo (
    .a(a[LO-1:0]), .b(b[LO-1:0]), .ci(ci), .s(s_lo), .co(c_lo)
  );
  csel_rca #(.W(HI)) u_hi0 (
    .a(a[W-1:LO]), .b(b[W-1:LO]), .ci(1'b0), .s(s_hi0), .co(c_hi0)
  );
  csel_rca #(.W(HI)) u_hi1 (
    .a(a[W-1:LO]), .b(b[W-1:LO]), .ci(1'b1), .s(s_hi1), .co(c_hi1)
  );

  assign s  = {(c_lo ? s_hi1 : s_hi0), s_lo};
  assign co = c_lo ? c_hi1 : c_hi0;
endmodule

// File: rtl/addsub_csel32.sv
module addsub_csel32
  import addsub_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_sub,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] sum_q,
  output logic         cout_q,
  output logic         ovf_q
);
  localparam int LO = W / 2;
  localparam int HI = W - LO;

  logic [W-1:0]  b_eff;
  logic [LO-1:0] s_lo;
  logic          c_lo;
  logic [HI-1:0] s_hi0, s_hi1;
  logic          c_hi0, c_hi1;
  logic [W-1:0]  s_all;
  logic          c_out, c_into_msb;

  // Subtraction: invert B, carry-in 1
  assign b_eff = b_in ^ {W{op_sub}};

  csel_block #(.W(LO)) u_lo (
    .a(a_in[LO-1:0]), .b(b_eff[LO-1:0]), .ci(op_sub), .s(s_lo), .co(c_lo)
  );
  csel_block #(.W(HI)) u_hi0 (
    .a(a_in[W-1:LO]), .b(b_eff[W-1:LO]), .ci(1'b0), .s(s_hi0), .co(c_hi0)
  );
  csel_block #(.W(HI)) u_hi1 (
    .a(a_in[W-1:LO]), .b(b_eff[W-1:LO]), .ci(1'b1), .s(s_hi1), .co(c_hi1)
  );

  assign s_all      = {(c_lo ? s_hi1 : s_hi0), s_lo};
  assign c_out      = c_lo ? c_hi1 : c_hi0;
  assign c_into_msb = s_all[W-1] ^ a_in[W-1] ^ b_eff[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      sum_q  <= s_all;
      cout_q <= c_out;
      ovf_q  <= c_into_msb ^ c_out;
    end
  end

  // R1, R8, R9: add result matches full-width sum one edge later
  assert_add_R1: assert property (@(posedge clk) disable iff (rst)
    !op_sub |=> (sum_q == $past(a_in) + $past(b_in)));
  // R2
  assert_sub_R2: assert property (@(posedge clk) disable iff (rst)
    op_sub |=> (sum_q == $past(a_in) - $past(b_in)));
  // R3: carry on add iff a > ~b
  assert_cout_add_R3: assert property (@(posedge clk) disable iff (rst)
    !op_sub |=> (cout_q == ($past(a_in) > ~$past(b_in))));
  // R4: no borrow iff a >= b
  assert_cout_sub_R4: assert property (@(posedge clk) disable iff (rst)
    op_sub |=> (cout_q == ($past(a_in) >= $past(b_in))));
  assert_ovf_add_R5: assert property (@(posedge clk) disable iff (rst)
    !op_sub |=> (ovf_q == (($past(a_in[W-1]) == $past(b_in[W-1])) &&
                           (sum_q[W-1] != $past(a_in[W-1])))));
  assert_ovf_sub_R6: assert property (@(posedge clk) disable iff (rst)
    op_sub |=> (ovf_q == (($past(a_in[W-1]) != $past(b_in[W-1])) &&
                          (sum_q[W-1] != $past(a_in[W-1])))));
  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q && !ovf_q));
endmodule

// File: tb/sim_addsub_csel32.sv
`timescale 1ns/1ps
module sim_addsub_csel32;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_sub = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] sum_q;
  logic         cout_q, ovf_q;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [W-1:0] s;
    logic         c;
    logic         v;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  addsub_csel32 u0 (
    .clk(clk), .rst(rst), .op_sub(op_sub), .a_in(a_in), .b_in(b_in),
    .sum_q(sum_q), .cout_q(cout_q), .ovf_q(ovf_q)
  );

  // Driver: apply one operation per cycle and queue its expectation (R8)
  task automatic drive(input logic sub, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string extra);
    exp_t e;
    logic [W:0] wide;
    @(negedge clk);
    op_sub = sub; a_in = a; b_in = b;
    if (!sub) begin
      wide = {1'b0, a} + {1'b0, b};
      e.s = wide[W-1:0];
      e.c = wide[W];
      e.v = (a[W-1] == b[W-1]) && (e.s[W-1] != a[W-1]);
    end else begin
      e.s = a - b;
      e.c = (a >= b);
      e.v = (a[W-1] != b[W-1]) && (e.s[W-1] != a[W-1]);
    end
    exp_q.push_back(e);
    tag_q.push_back({sub ? "R2 R4 R6" : "R1 R3 R5", extra});
  endtask

  // Monitor: compare results one edge after each driven item
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (sum_q !== e.s || cout_q !== e.c || ovf_q !== e.v) begin
        fails++;
        $display("FAIL %s: got sum=%h c=%b v=%b expected sum=%h c=%b v=%b",
                 t, sum_q, cout_q, ovf_q, e.s, e.c, e.v);
      end
    end
  end

  task automatic check_zero(input string t);
    checks++;
    if (sum_q !== '0 || cout_q !== 1'b0 || ovf_q !== 1'b0) begin
      fails++;
      $display("FAIL %s: got sum=%h c=%b v=%b expected sum=0 c=0 v=0",
               t, sum_q, cout_q, ovf_q);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_zero("R7 initial reset");
    rst = 1'b0;

    // Sign and all-ones corners
    drive(0, 32'h0000_0000, 32'h0000_0000, "");
    drive(0, 32'h7FFF_FFFF, 32'h0000_0001, "");
    drive(0, 32'h8000_0000, 32'h8000_0000, "");
    drive(0, 32'hFFFF_FFFF, 32'h0000_0001, "");
    drive(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "");
    drive(1, 32'h0000_0000, 32'h0000_0001, "");
    drive(1, 32'h8000_0000, 32'h0000_0001, "");
    drive(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "");
    drive(1, 32'h0000_0005, 32'h0000_0005, "");
    drive(1, 32'h8000_0000, 32'h7FFF_FFFF, "");
    drive(1, 32'hFFFF_FFFF, 32'h8000_0000, "");
    // R9: carries across the select boundaries
    drive(0, 32'h0000_00FF, 32'h0000_0001, " R9");
    drive(0, 32'h0000_FFFF, 32'h0000_0001, " R9");
    drive(0, 32'h00FF_FFFF, 32'h0000_0001, " R9");
    drive(0, 32'h00FF_00FF, 32'h0001_0001, " R9");
    drive(1, 32'h0001_0000, 32'h0000_0001, " R9");
    drive(1, 32'h0100_0000, 32'h0000_0001, " R9");
    drive(1, 32'h0000_0100, 32'h0000_0001, " R9");
    // R8: back-to-back pseudo-random operations of both kinds
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (i % 5 == 0) rb = ~ra + (i % 3);
      drive(logic'(i % 2), ra, rb, " R8");
    end

    // Mid-run reset clears nonzero outputs (R7)
    drive(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "");
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_zero("R7 mid-run reset");
    rst = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule